// File: doc/BRIEF.md
# Stereo DAC Sample-Hold Sequencer

This block produces a stereo analog output from one shared 12-bit D/A converter. Each cycle of its output sequence writes a 16-bit word to a digital output port. The word carries the converter code together with four sample-and-hold control lines. Each channel has two hold stages. The first-rank stage of a channel captures the shared converter output while that channel's code is being presented. Afterwards, both second-rank stages sample at the same moment, so the final left and right outputs change together rather than one step apart.

Playback starts with a pulse on `start`. The block then steps through a fixed six-step pattern for every sample pair, and each step lasts one microsecond, measured in clock cycles by a parameter. It shows the current pair index on `sample_idx`, and an external store returns the matching right and left codes through combinational reads. After the number of pairs given at start, the block pulses `done` and goes idle.

Top module: `sh_dac_seq`

## Requirements
- R1: After reset, `port_word` is 0, `busy` is 0, `done` is 0 and `sample_idx` is 0. While idle the block drives `port_word` to 0.
- R2: `port_word` layout: bits [11:0] hold the converter code, bit 12 is right first rank, bit 13 is right second rank, bit 14 is left first rank and bit 15 is left second rank. A control bit of 1 means sample and 0 means hold.
- R3: Every step lasts exactly CYC_PER_US clock cycles. The step timer restarts from zero when playback starts, and the first step begins in the cycle after the clock edge that accepts `start`.
- R4: Step 1 presents the right code, with only bit 12 set.
- R5: Step 2 presents the right code with all four control bits at hold.
- R6: Step 3 presents the left code, with only bit 14 set.
- R7: Step 4 presents the left code with all control bits at hold.
- R8: Step 5 presents the left code with bits 13 and 15 set together and bits 12 and 14 at hold. Bits 13 and 15 are always equal.
- R9: Step 6 presents the left code with all bits at hold. `sample_idx` is constant through a pair and increments by one at the end of step 6.
- R10: After step 6 of pair number `pair_count`-1, `done` is high for exactly one cycle. In that same cycle the block is idle with `sample_idx` back at 0.
- R11: `start` is ignored while `busy` is high or when `pair_count` is 0. The value of `pair_count` is captured at start, so later changes have no effect on a run in progress.
- R12: The two first-rank bits are never 1 together, and no first-rank bit is 1 while a second-rank bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin playback when idle |
| pair_count | input | IDX_W | Number of sample pairs to play |
| right_code | input | 12 | Right-channel code for the current index |
| left_code | input | 12 | Left-channel code for the current index |
| port_word | output | 16 | Converter code plus four hold controls |
| sample_idx | output | IDX_W | Current sample pair index |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle pulse at end of playback |

## Verification
The bench builds the block with CYC_PER_US=3 and IDX_W=4. With a three-cycle step, every boundary of every step is covered cycle by cycle across runs of 1, 3, 5 and 15 pairs. The 4-bit index makes the largest count, 15, cheap to reach, so the final-pair comparison and the return to index 0 are exercised at the top of the index range. Runs that set `start` and change `pair_count` in the middle of playback, plus a start with a zero count, cover the cases where the input must be ignored.

// File: rtl/sh_seq_pkg.sv
package sh_seq_pkg;

    localparam int CODE_W = 12;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RSMP = 3'd1,
        PH_RHLD = 3'd2,
        PH_LSMP = 3'd3,
        PH_LHLD = 3'd4,
        PH_XFER = 3'd5,
        PH_SETL = 3'd6
    } phase_e;

    typedef struct packed {
        logic              l_out;
        logic              l_in;
        logic              r_out;
        logic              r_in;
        logic [CODE_W-1:0] code;
    } port_word_t;

    function automatic phase_e next_phase(input phase_e ph);
        case (ph)
            PH_RSMP: return PH_RHLD;
            PH_RHLD: return PH_LSMP;
            PH_LSMP: return PH_LHLD;
            PH_LHLD: return PH_XFER;
            PH_XFER: return PH_SETL;
            default: return PH_RSMP;
        endcase
    endfunction

endpackage

// File: rtl/sh_step_timer.sv
module sh_step_timer #(
    parameter int CYC_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic step_end
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    logic [CW-1:0] cnt;

    assign step_end = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || step_end) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sh_phase_seq.sv
module sh_phase_seq
    import sh_seq_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] pair_count,
    input  logic             step_end,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    logic [IDX_W-1:0] total;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            total <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start && pair_count != '0) begin
                    phase <= PH_RSMP;
                    idx   <= '0;
                    total <= pair_count;
                end
            end else if (step_end) begin
                if (phase == PH_SETL) begin
                    if (idx == total - 1'b1) begin
                        phase <= PH_IDLE;
                        idx   <= '0;
                        done  <= 1'b1;
                    end else begin
                        phase <= PH_RSMP;
                        idx   <= idx + 1'b1;
                    end
                end else begin
                    phase <= next_phase(phase);
                end
            end
        end
    end

    AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !step_end) |=> $stable(phase)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_IDX_STEADY: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_SETL) |=> $stable(idx)); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE && idx == '0)); // R10
endmodule

// File: rtl/sh_word_enc.sv
module sh_word_enc
    import sh_seq_pkg::*;
(
    input  phase_e             phase,
    input  logic [CODE_W-1:0]  right_code,
    input  logic [CODE_W-1:0]  left_code,
    output port_word_t         word
);
    always_comb begin
        word = '0;
        case (phase)
            PH_RSMP: begin word.code = right_code; word.r_in = 1'b1; end
            PH_RHLD: word.code = right_code;
            PH_LSMP: begin word.code = left_code; word.l_in = 1'b1; end
            PH_LHLD: word.code = left_code;
            PH_XFER: begin
                word.code  = left_code;
                word.r_out = 1'b1;
                word.l_out = 1'b1;
            end
            PH_SETL: word.code = left_code;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/sh_dac_seq.sv
module sh_dac_seq
    import sh_seq_pkg::*;
#(
    parameter int CYC_PER_US = 100,
    parameter int IDX_W      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  pair_count,
    input  logic [11:0]       right_code,
    input  logic [11:0]       left_code,
    output logic [15:0]       port_word,
    output logic [IDX_W-1:0]  sample_idx,
    output logic              busy,
    output logic              done
);
    phase_e     phase;
    logic       step_end;
    port_word_t word;

    assign busy = (phase != PH_IDLE);

    sh_step_timer #(.CYC_PER_US(CYC_PER_US)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .step_end (step_end)
    );

    sh_phase_seq #(.IDX_W(IDX_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pair_count (pair_count),
        .step_end   (step_end),
        .phase      (phase),
        .idx        (sample_idx),
        .done       (done)
    );

    sh_word_enc i_enc (
        .phase      (phase),
        .right_code (right_code),
        .left_code  (left_code),
        .word       (word)
    );

    assign port_word = word;

    AST_FIRST_RANK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(port_word[12] && port_word[14])); // R12
    AST_RANKS_APART: assert property (@(posedge clk) disable iff (rst)
        (port_word[12] || port_word[14]) |-> !(port_word[13] || port_word[15])); // R12
    AST_XFER_PAIRED: assert property (@(posedge clk) disable iff (rst)
        port_word[13] == port_word[15]); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (port_word == '0)); // R1
endmodule

// File: tb/test_sh_dac_seq.sv
module test_sh_dac_seq;
    localparam int CYC   = 3;
    localparam int IDX_W = 4;

    typedef struct {
        logic [15:0]      word;
        logic [IDX_W-1:0] idx;
        logic             busy;
        logic             done;
        string            req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IDX_W-1:0] pair_count = '0;
    logic [11:0] right_code, left_code;
    logic [15:0] port_word;
    logic [IDX_W-1:0] sample_idx;
    logic busy, done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic armed = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    function automatic logic [11:0] rval(input int i);
        return 12'((i * 37 + 5) & 12'hFFF);
    endfunction
    function automatic logic [11:0] lval(input int i);
        return 12'(12'hFFF - ((i * 53) & 12'h7FF));
    endfunction

    assign right_code = rval(int'(sample_idx));
    assign left_code  = lval(int'(sample_idx));

    sh_dac_seq #(.CYC_PER_US(CYC), .IDX_W(IDX_W)) i_sh_dac_seq (
        .clk(clk), .rst(rst), .start(start), .pair_count(pair_count),
        .right_code(right_code), .left_code(left_code),
        .port_word(port_word), .sample_idx(sample_idx),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected item per cycle while armed
    always @(negedge clk) begin
        if (armed && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, port_word == e.word, "port_word", 32'(port_word), 32'(e.word));
            check(e.req, sample_idx == e.idx, "sample_idx", 32'(sample_idx), 32'(e.idx));
            check(e.req, busy == e.busy, "busy", 32'(busy), 32'(e.busy));
            check(e.req, done == e.done, "done", 32'(done), 32'(e.done));
        end
    end

    task automatic push(input logic [15:0] w, input int i, input logic b,
                        input logic d, input string r);
        exp_t e;
        e.word = w; e.idx = IDX_W'(i); e.busy = b; e.done = d; e.req = r;
        q.push_back(e);
    endtask

    // Driver: predicts the whole run from the requirements
    task automatic run(input int n, input bit poke);
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < CYC; c++) push({4'b0001, rval(p)}, p, 1, 0, "R4");
            for (int c = 0; c < CYC; c++) push({4'b0000, rval(p)}, p, 1, 0, "R5");
            for (int c = 0; c < CYC; c++) push({4'b0100, lval(p)}, p, 1, 0, "R6");
            for (int c = 0; c < CYC; c++) push({4'b0000, lval(p)}, p, 1, 0, "R7");
            for (int c = 0; c < CYC; c++) push({4'b1010, lval(p)}, p, 1, 0, "R8");
            for (int c = 0; c < CYC; c++) push({4'b0000, lval(p)}, p, 1, 0, "R9");
        end
        push(16'h0000, 0, 0, 1, "R10");
        push(16'h0000, 0, 0, 0, "R10");
        push(16'h0000, 0, 0, 0, "R1");
        @(negedge clk);
        pair_count = IDX_W'(n);
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        armed = 1'b1;
        if (poke) begin
            repeat (7) @(negedge clk);
            start = 1'b1;                 // R11: ignored while busy
            pair_count = IDX_W'(1);       // R11: captured value stays
            @(negedge clk);
            start = 1'b0;
            repeat (CYC * 6) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (q.size() == 0);
        armed = 1'b0;
    endtask

    task automatic zero_start();
        for (int c = 0; c < 6; c++) push(16'h0000, 0, 0, 0, "R11");
        @(negedge clk);
        pair_count = '0;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        armed = 1'b1;
        wait (q.size() == 0);
        armed = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", port_word == 16'h0, "reset port_word", 32'(port_word), 0);
        check("R1", busy == 1'b0, "reset busy", 32'(busy), 0);
        check("R1", done == 1'b0, "reset done", 32'(done), 0);
        check("R1", sample_idx == '0, "reset idx", 32'(sample_idx), 0);
        run(1, 0);   // R2 R3 single pair
        run(3, 0);   // R3 R9 index advance
        run(5, 1);   // R11 start and count changes mid-run
        zero_start();// R11 zero count
        run(15, 0);  // R10 top of index range
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule